// File: doc/BRIEF.md
# Oversampling Serial Receiver with Break Tracking

This block turns an asynchronous serial line into parallel characters. A one-cycle enable, `tick16`, fires sixteen times per bit period. The receiver uses it to find the start bit, to sample each later bit at its centre, and to check the parity bit and the stop bit. Each finished character goes into a single holding register. That register raises `rx_valid` and keeps the character until the consumer pulses `rd_ack`.

The line format is set with static configuration inputs, which match the transmitter's settings: five to eight data bits and one of four parity modes. Error flags travel with each character: parity mismatch, framing error and break character. A sticky overrun flag reports a character that was lost because the holding register was still full. The block also gives two one-cycle pulses on the line's break condition: one when a break is recognised and one when the line goes idle again. A break is recognised both when a whole character is zero and when the line drops low partway through a character and stays low.

Top module: `uart_rx16`

## Requirements
- R1: `cfg_bits` selects the data length: 00 means 5 bits, 01 means 6, 10 means 7 and 11 means 8. Bits arrive least significant first. They appear in the low bits of `rx_data`, and the unused upper bits read zero.
- R2: `cfg_par` selects the parity mode: 00 means no parity bit, 01 means even, 10 means odd and 11 means the bit must equal `cfg_par_val`. A received parity bit that differs from the expected value sets `err_parity` for that character.
- R3: A low level found at a tick while idle starts a character only if the line is still low eight ticks later. Otherwise the receiver returns to idle and delivers nothing.
- R4: A low stop-bit sample on a character that is not a break sets `err_frame` for that character.
- R5: A character counts as a break when its data bits are all zero, its parity bit (if present) is zero and its stop bit is low. Such a character is delivered as zero with `err_break` set and with `err_frame` and `err_parity` clear, and `brk_start` pulses for one cycle.
- R6: After a framing error, a break is recognised when the line stays low for one full character time, counted in ticks from the point where the line went low. `brk_start` then pulses and no further character is delivered while the line stays low.
- R7: Once a break has been recognised, the first tick that finds the line high pulses `brk_end` for one cycle. The receiver then accepts characters again.
- R8: A character that completes while `rx_valid` is high and `rd_ack` is low sets `err_overrun` and leaves `rx_data` unchanged. `rd_ack` clears both `rx_valid` and `err_overrun`.
- R9: After reset, `rx_valid`, every error flag and both break pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sampling enable, sixteen per bit period |
| rx_in | input | 1 | Serial line, idle high |
| cfg_bits | input | 2 | Data length select |
| cfg_par | input | 2 | Parity mode select |
| cfg_par_val | input | 1 | Required parity level in forced mode |
| rd_ack | input | 1 | Consumer has taken the held character |
| rx_data | output | 8 | Held character |
| rx_valid | output | 1 | Holding register full |
| err_parity | output | 1 | Parity mismatch on held character |
| err_frame | output | 1 | Low stop bit on held character |
| err_break | output | 1 | Held character was a break |
| err_overrun | output | 1 | A character was lost since the last read |
| brk_start | output | 1 | One-cycle pulse: break recognised |
| brk_end | output | 1 | One-cycle pulse: line back high after a break |

## Verification
Some properties are checked by assertions on every cycle. Held data stays stable until it is read, a rejected start returns to idle, and each break pulse lasts one cycle. The end pulse only follows a recognised break, and a held character never carries both the framing and break flags. The correctness of the assembled data and parity for every length and mode can only be shown by the bench's random frames. The same goes for the rejection of a short low glitch, the overrun ordering, and the two break paths (all-zero and mid-character) with their start and end pulses.

// File: rtl/uart_rx16.sv
module uart_rx16 #(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          rx_in,
  input  logic [1:0]    cfg_bits,
  input  logic [1:0]    cfg_par,
  input  logic          cfg_par_val,
  input  logic          rd_ack,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          err_parity,
  output logic          err_frame,
  output logic          err_break,
  output logic          err_overrun,
  output logic          brk_start,
  output logic          brk_end
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2 - 1;
  localparam int LW  = $clog2(OSR * (DW + 3) + 1);
  localparam int BW  = $clog2(DW);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD, S_BRK} st_t;

  st_t            st;
  logic [1:0]     sync;
  logic [CW-1:0]  cnt;
  logic [BW-1:0]  bidx;
  logic [DW-1:0]  shreg;
  logic           par_bit;
  logic [LW-1:0]  lowrun;

  wire rx_s    = sync[1];
  wire has_par = cfg_par != 2'b00;
  wire at_mid  = cnt == CW'(OSR - 1);

  logic [3:0]    nbits;
  logic [DW-1:0] aligned;
  logic [LW-1:0] frame_ticks;
  logic          exp_par;
  logic          is_brk;

  always_comb begin
    nbits       = 4'd5 + {2'b00, cfg_bits};
    aligned     = shreg >> (DW - int'(nbits));
    frame_ticks = LW'(OSR * (2 + int'(nbits) + int'(has_par)));
    case (cfg_par)
      2'b01:   exp_par = ^aligned;
      2'b10:   exp_par = ~^aligned;
      default: exp_par = cfg_par_val;
    endcase
    is_brk = !rx_s && (aligned == '0) && !(has_par && par_bit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rx_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      bidx        <= '0;
      shreg       <= '0;
      par_bit     <= 1'b0;
      lowrun      <= '0;
      rx_data     <= '0;
      rx_valid    <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_break   <= 1'b0;
      err_overrun <= 1'b0;
      brk_start   <= 1'b0;
      brk_end     <= 1'b0;
    end else begin
      brk_start <= 1'b0;
      brk_end   <= 1'b0;
      if (rd_ack) begin
        rx_valid    <= 1'b0;
        err_overrun <= 1'b0;
      end
      if (tick16) begin
        if (rx_s)                      lowrun <= '0;
        else if (lowrun != {LW{1'b1}}) lowrun <= lowrun + 1'b1;
        case (st)
          S_IDLE: if (!rx_s) begin
            st  <= S_START;
            cnt <= '0;
          end
          S_START: if (cnt == CW'(MID)) begin
            cnt  <= '0;
            bidx <= '0;
            st   <= rx_s ? S_IDLE : S_DATA;
          end else cnt <= cnt + 1'b1;
          S_DATA: if (at_mid) begin
            cnt   <= '0;
            shreg <= {rx_s, shreg[DW-1:1]};
            bidx  <= bidx + 1'b1;
            if (bidx == BW'(nbits - 4'd1)) st <= has_par ? S_PAR : S_STOP;
          end else cnt <= cnt + 1'b1;
          S_PAR: if (at_mid) begin
            cnt     <= '0;
            par_bit <= rx_s;
            st      <= S_STOP;
          end else cnt <= cnt + 1'b1;
          S_STOP: if (at_mid) begin
            cnt <= '0;
            if (rx_valid && !rd_ack) err_overrun <= 1'b1;
            else begin
              rx_valid   <= 1'b1;
              rx_data    <= aligned;
              err_parity <= has_par && !is_brk && (par_bit != exp_par);
              err_frame  <= !rx_s && !is_brk;
              err_break  <= is_brk;
            end
            if (is_brk) brk_start <= 1'b1;
            st <= rx_s ? S_IDLE : (is_brk ? S_BRK : S_HOLD);
          end else cnt <= cnt + 1'b1;
          S_HOLD: if (rx_s) st <= S_IDLE;
            else if (lowrun >= frame_ticks) begin
              brk_start <= 1'b1;
              st        <= S_BRK;
            end
          S_BRK: if (rx_s) begin
            brk_end <= 1'b1;
            st      <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  p_false_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && tick16 && cnt == CW'(MID) && rx_s) |=> (st == S_IDLE && !brk_start));

  p_hold_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rd_ack) |=> (rx_valid && $stable(rx_data)));

  p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_start |=> !brk_start);

  p_end_after_brk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_end |-> ($past(st == S_BRK) && !brk_start));

  p_flag_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !(err_frame && err_break));

  p_break_no_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && err_break) |-> (!err_parity && rx_data == '0));
endmodule

// File: tb/uart_rx16_tb.sv
module uart_rx16_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rx_in = 1'b1;
  logic [1:0] cfg_bits = 2'b11;
  logic [1:0] cfg_par = 2'b00;
  logic       cfg_par_val = 1'b0;
  logic       rd_ack = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, err_parity, err_frame, err_break, err_overrun, brk_start, brk_end;

  int n_chk = 0, n_fail = 0, n_bs = 0, n_be = 0, n_vr = 0, tcnt = 0;
  logic prev_v = 1'b0;

  uart_rx16 u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in),
    .cfg_bits(cfg_bits), .cfg_par(cfg_par), .cfg_par_val(cfg_par_val), .rd_ack(rd_ack),
    .rx_data(rx_data), .rx_valid(rx_valid), .err_parity(err_parity), .err_frame(err_frame),
    .err_break(err_break), .err_overrun(err_overrun), .brk_start(brk_start), .brk_end(brk_end)
  );

  always #5 clk = ~clk;

  initial forever begin
    @(negedge clk);
    tcnt++;
    tick16 = (tcnt % 4 == 0);
  end

  always @(negedge clk) begin
    if (brk_start) n_bs++;
    if (brk_end) n_be++;
    if (rx_valid && !prev_v) n_vr++;
    prev_v = rx_valid;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic par_of(input logic [7:0] d, input int nb, input logic [1:0] pm, input logic pv);
    logic x = 1'b0;
    for (int i = 0; i < nb; i++) x ^= d[i];
    case (pm)
      2'b01:   return x;
      2'b10:   return ~x;
      default: return pv;
    endcase
  endfunction

  task automatic bit_out(input logic v, input int nbits_time);
    rx_in = v;
    repeat (64 * nbits_time) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic flip, input logic stopv);
    int nb = 5 + int'(cfg_bits);
    bit_out(1'b0, 1);
    for (int i = 0; i < nb; i++) bit_out(d[i], 1);
    if (cfg_par != 2'b00) bit_out(par_of(d, nb, cfg_par, cfg_par_val) ^ flip, 1);
    bit_out(stopv, 1);
    rx_in = 1'b1;
    repeat (48) @(negedge clk);
  endtask

  task automatic ack();
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d, m;
    logic flip, stopv;
    int nb, vr0, bs0, be0;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    check("R9 valid", rx_valid, 0);
    check("R9 flags", {err_parity, err_frame, err_break, err_overrun, brk_start, brk_end}, 0);

    for (int it = 0; it < 40; it++) begin
      cfg_bits = 2'($urandom % 4);
      cfg_par = 2'($urandom % 4);
      cfg_par_val = 1'($urandom % 2);
      nb = 5 + int'(cfg_bits);
      m = 8'((1 << nb) - 1);
      d = 8'($urandom) & m;
      flip = ($urandom % 5 == 0) && (cfg_par != 2'b00);
      stopv = ($urandom % 6 != 0);
      if (!stopv && d == 8'h00 && (cfg_par == 2'b00 || (par_of(d, nb, cfg_par, cfg_par_val) ^ flip) == 1'b0))
        stopv = 1'b1;
      send(d, flip, stopv);
      check("R1 valid", rx_valid, 1);
      check("R1 data", rx_data, d);
      check("R2 parity flag", err_parity, flip);
      check("R4 frame flag", err_frame, !stopv);
      check("R5 no break", err_break, 0);
      ack();
      check("R8 ack clears", rx_valid, 0);
    end

    cfg_bits = 2'b11; cfg_par = 2'b00;
    vr0 = n_vr;
    rx_in = 1'b0;
    repeat (16) @(negedge clk);
    rx_in = 1'b1;
    repeat (192) @(negedge clk);
    check("R3 false start no char", n_vr - vr0, 0);
    check("R3 false start valid", rx_valid, 0);
    send(8'hA5, 1'b0, 1'b1);
    check("R3 next char ok", rx_data, 8'hA5);
    ack();

    send(8'h3C, 1'b0, 1'b1);
    send(8'hC3, 1'b0, 1'b1);
    check("R8 old data kept", rx_data, 8'h3C);
    check("R8 overrun set", err_overrun, 1);
    ack();
    check("R8 overrun cleared", err_overrun, 0);
    check("R8 valid cleared", rx_valid, 0);

    cfg_par = 2'b10;
    bs0 = n_bs; be0 = n_be;
    bit_out(1'b0, 14);
    check("R5 break valid", rx_valid, 1);
    check("R5 break data", rx_data, 0);
    check("R5 break flag", err_break, 1);
    check("R5 no frame", err_frame, 0);
    check("R5 no parity", err_parity, 0);
    check("R5 brk_start", n_bs - bs0, 1);
    ack();
    check("R7 no end yet", n_be - be0, 0);
    bit_out(1'b1, 2);
    check("R7 brk_end", n_be - be0, 1);
    check("R7 no char at end", rx_valid, 0);
    send(8'h5A, 1'b0, 1'b1);
    check("R7 resumes", rx_data, 8'h5A);
    check("R7 resumes parity", err_parity, 0);
    ack();

    cfg_par = 2'b00;
    bs0 = n_bs; be0 = n_be; vr0 = n_vr;
    bit_out(1'b0, 1);
    bit_out(1'b1, 3);
    bit_out(1'b0, 9);
    check("R6 no break yet", n_bs - bs0, 0);
    check("R4 mid frame err", err_frame, 1);
    check("R6 data", rx_data, 8'h07);
    bit_out(1'b0, 11);
    check("R6 brk_start", n_bs - bs0, 1);
    check("R6 one char", n_vr - vr0, 1);
    bit_out(1'b1, 2);
    check("R7 mid brk_end", n_be - be0, 1);
    ack();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule